// File: doc/BRIEF.md
# Double-Precision Floating-Point Compare Unit

This block orders two IEEE-754 double-precision operands and reports the outcome as a one-hot 4-bit code meaning less-than, greater-than, equal or unordered. The code is merged into one selectable 4-bit field of a 32-bit condition register that the block keeps, and the same code is presented as the floating-point condition code of the status register. Alongside the code, the block raises set strobes for the status flags that a compare can touch: the exception summary, the invalid-operation summary, the signaling-NaN invalid flag and the invalid-compare flag.

Two variants exist. The unordered variant only complains about signaling NaNs. The ordered variant treats any NaN as an invalid operation, and it also raises the invalid-compare flag when a quiet NaN is involved or when the caller reports that the enabled-exception summary is clear. The ordering is decided on the sign-magnitude encodings with no subtract. The compare itself is combinational, and all results are registered on a valid strobe.

Top module: `fcmp_unit`

## Requirements
- R1: After synchronous reset, cond_reg, fp_cc and flag_set are all zero and out_valid is low.
- R2: fp_cc is one-hot whenever out_valid is high. Its encoding is bit 3 = less-than, bit 2 = greater-than, bit 1 = equal, bit 0 = unordered.
- R3: For non-NaN operands, including infinities and subnormals, the code is less-than when op_a < op_b, greater-than when op_a > op_b, and equal otherwise.
- R4: Positive and negative zero compare equal in every combination.
- R5: If either operand is a NaN (exponent all ones, fraction non-zero), the code is unordered.
- R6: The code replaces bits [31-4f : 28-4f] of cond_reg, where f is field_idx, with bit 3 of the code at bit 31-4f. All other bits of cond_reg keep their previous value.
- R7: fp_cc carries the same code that was merged into cond_reg.
- R8: In the unordered variant (ordered_mode = 0), flag_set is 4'b1110 when either operand is a signaling NaN (exponent all ones, fraction non-zero, fraction bit 51 clear) and 4'b0000 otherwise. Quiet NaNs raise nothing. The bits of flag_set are [3] summary, [2] invalid summary, [1] signaling-NaN, [0] invalid compare.
- R9: In the ordered variant (ordered_mode = 1), any NaN operand sets bits 3 and 2. Bit 1 is set when an operand is a signaling NaN. Bit 0 is set when an operand is a quiet NaN (exponent all ones, bit 51 set) or when exc_summary is 0. Without a NaN, flag_set is 4'b0000.
- R10: Results appear one cycle after in_valid, with out_valid high for that one cycle. In a cycle without in_valid, cond_reg and fp_cc hold their values, the next cycle's flag_set is zero and out_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op_a | input | 64 | First double-precision operand |
| op_b | input | 64 | Second double-precision operand |
| field_idx | input | 3 | Destination field of the condition register |
| ordered_mode | input | 1 | 1 = ordered variant, 0 = unordered variant |
| exc_summary | input | 1 | Current enabled-exception summary bit |
| cond_reg | output | 32 | Condition register after the merge |
| fp_cc | output | 4 | Floating-point condition code of the last compare |
| flag_set | output | 4 | Status-flag set strobes, valid with out_valid |
| out_valid | output | 1 | Results of a compare are present |

## Verification
Two decisions fall in the same cycle: the ordering code and the invalid-flag strobes. Both come from the same classification of the operands, and both are registered together. The sweep pairs every operand class, including quiet and signaling NaNs of both signs, zeros, infinities, extremes and subnormals, in both variants and with the summary bit at both values. In each of these cycles the bench judges the code, the merged register and the flag vector against values that it derives separately from the operand bits and real-number comparison. Because the destination field rotates across the sweep, every field placement also meets each flag outcome.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    localparam int DBL_W   = 64;
    localparam int EXP_W   = 11;
    localparam int FRAC_W  = 52;
    localparam int MAG_W   = DBL_W - 1;
    localparam int QUIET_B = FRAC_W - 1;

    // bit 3 = lt, 2 = gt, 1 = eq, 0 = un
    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic un;
    } cmp_code_t;

    // bit 3 = summary, 2 = invalid summary, 1 = signaling NaN, 0 = invalid compare
    typedef struct packed {
        logic fx;
        logic vx;
        logic snan;
        logic vc;
    } flag_vec_t;

    typedef struct packed {
        logic             sign;
        logic             is_nan;
        logic             is_snan;
        logic             is_qnan;
        logic             is_zero;
        logic [MAG_W-1:0] mag;
    } op_class_t;

    function automatic op_class_t classify_op(input logic [DBL_W-1:0] v);
        op_class_t c;
        logic      exp_ones;
        logic      frac_nz;
        exp_ones  = &v[DBL_W-2 -: EXP_W];
        frac_nz   = |v[FRAC_W-1:0];
        c.sign    = v[DBL_W-1];
        c.mag     = v[MAG_W-1:0];
        c.is_nan  = exp_ones & frac_nz;
        c.is_qnan = exp_ones & v[QUIET_B];
        c.is_snan = exp_ones & frac_nz & ~v[QUIET_B];
        c.is_zero = ~|v[MAG_W-1:0];
        return c;
    endfunction

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
    import fcmp_pkg::*;
(
    input  logic [DBL_W-1:0] operand,
    output op_class_t        info
);
    always_comb info = classify_op(operand);
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
    import fcmp_pkg::*;
(
    input  op_class_t a,
    input  op_class_t b,
    output cmp_code_t code
);
    logic mag_lt;
    logic mag_eq;

    always_comb begin
        mag_lt = a.mag < b.mag;
        mag_eq = a.mag == b.mag;
        code   = '0;
        if (a.is_nan || b.is_nan) begin
            code.un = 1'b1;
        end else if (a.is_zero && b.is_zero) begin
            code.eq = 1'b1;
        end else if (a.sign != b.sign) begin
            code.lt = a.sign;
            code.gt = ~a.sign;
        end else if (mag_eq) begin
            code.eq = 1'b1;
        end else begin
            // negative operands invert the magnitude order
            code.lt = mag_lt ^ a.sign;
            code.gt = ~(mag_lt ^ a.sign);
        end
    end
endmodule

// File: rtl/fcmp_flags.sv
module fcmp_flags
    import fcmp_pkg::*;
(
    input  op_class_t a,
    input  op_class_t b,
    input  logic      ordered,
    input  logic      summary,
    output flag_vec_t flags
);
    logic any_nan;
    logic any_snan;
    logic any_qnan;

    always_comb begin
        any_nan  = a.is_nan  | b.is_nan;
        any_snan = a.is_snan | b.is_snan;
        any_qnan = a.is_qnan | b.is_qnan;
        flags    = '0;
        if (ordered) begin
            if (any_nan) begin
                flags.fx   = 1'b1;
                flags.vx   = 1'b1;
                flags.snan = any_snan;
                flags.vc   = any_qnan | ~summary;
            end
        end else if (any_snan) begin
            flags.fx   = 1'b1;
            flags.vx   = 1'b1;
            flags.snan = 1'b1;
        end
    end
endmodule

// File: rtl/fcmp_field_merge.sv
module fcmp_field_merge #(
    parameter int REG_W   = 32,
    parameter int FIELD_W = 4,
    localparam int NFIELD = REG_W / FIELD_W,
    localparam int IDX_W  = $clog2(NFIELD)
) (
    input  logic [REG_W-1:0]   cur,
    input  logic [IDX_W-1:0]   idx,
    input  logic [FIELD_W-1:0] value,
    output logic [REG_W-1:0]   merged
);
    // field 0 sits at the most significant end
    for (genvar g = 0; g < NFIELD; g++) begin : g_field
        localparam int HI = REG_W - 1 - g * FIELD_W;
        always_comb begin
            if (idx == IDX_W'(g))
                merged[HI -: FIELD_W] = value;
            else
                merged[HI -: FIELD_W] = cur[HI -: FIELD_W];
        end
    end
endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit
    import fcmp_pkg::*;
#(
    parameter int CR_W    = 32,
    parameter int FIELD_W = 4,
    localparam int NFIELD = CR_W / FIELD_W,
    localparam int IDX_W  = $clog2(NFIELD)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [DBL_W-1:0]   op_a,
    input  logic [DBL_W-1:0]   op_b,
    input  logic [IDX_W-1:0]   field_idx,
    input  logic               ordered_mode,
    input  logic               exc_summary,
    output logic [CR_W-1:0]    cond_reg,
    output logic [FIELD_W-1:0] fp_cc,
    output logic [3:0]         flag_set,
    output logic               out_valid
);
    logic [DBL_W-1:0] ops [2];
    op_class_t        cls [2];
    cmp_code_t        code;
    flag_vec_t        flags;
    logic [CR_W-1:0]  cr_next;

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    for (genvar i = 0; i < 2; i++) begin : g_cls
        fcmp_classify u_cls (.operand(ops[i]), .info(cls[i]));
    end

    fcmp_order u_order (.a(cls[0]), .b(cls[1]), .code(code));

    fcmp_flags u_flags (
        .a(cls[0]), .b(cls[1]),
        .ordered(ordered_mode), .summary(exc_summary),
        .flags(flags)
    );

    fcmp_field_merge #(.REG_W(CR_W), .FIELD_W(FIELD_W)) u_merge (
        .cur(cond_reg), .idx(field_idx),
        .value(FIELD_W'(code)), .merged(cr_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cond_reg  <= '0;
            fp_cc     <= '0;
            flag_set  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                cond_reg <= cr_next;
                fp_cc    <= FIELD_W'(code);
                flag_set <= flags;
            end else begin
                flag_set <= '0;
            end
        end
    end
endmodule

// File: rtl/fcmp_unit_chk.sv
module fcmp_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [2:0]  field_idx,
    input logic        ordered_mode,
    input logic        exc_summary,
    input logic [31:0] cond_reg,
    input logic [3:0]  fp_cc,
    input logic [3:0]  flag_set,
    input logic        out_valid
);
    a_r2_code_onehot: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $countones(fp_cc) == 1);

    a_r10_latency: assert property (@(posedge clk) disable iff (rst)
        out_valid == $past(in_valid));

    a_r10_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> ($stable(cond_reg) && $stable(fp_cc) && flag_set == 4'b0));

    a_r7_cc_in_field: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> 4'((cond_reg << (4 * $past(field_idx))) >> 28) == fp_cc);

    a_r6_others_kept: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((cond_reg ^ $past(cond_reg)) & ~(32'hF000_0000 >> (4 * $past(field_idx)))) == 32'h0);

    a_r8_unordered_no_vc: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !$past(ordered_mode)) |-> flag_set[0] == 1'b0);

    a_r9_flags_need_un: assert property (@(posedge clk) disable iff (rst)
        (out_valid && flag_set != 4'b0) |-> (fp_cc[0] && flag_set[3] && flag_set[2]));

    a_r9_summary_clear_vc: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(ordered_mode) && !$past(exc_summary) && fp_cc[0]) |-> flag_set[0]);
endmodule

bind fcmp_unit fcmp_unit_chk chk_i (.*);

// File: tb/fcmp_unit_tb_top.sv
module fcmp_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [63:0] op_a, op_b;
    logic [2:0]  field_idx;
    logic        ordered_mode, exc_summary;
    logic [31:0] cond_reg;
    logic [3:0]  fp_cc, flag_set;
    logic        out_valid;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;   // 125 MHz

    fcmp_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .field_idx(field_idx),
        .ordered_mode(ordered_mode), .exc_summary(exc_summary),
        .cond_reg(cond_reg), .fp_cc(fp_cc), .flag_set(flag_set),
        .out_valid(out_valid)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [63:0] pick(input int k);
        case (k)
            0:  pick = 64'h0000_0000_0000_0000; // +0
            1:  pick = 64'h8000_0000_0000_0000; // -0
            2:  pick = 64'h3FF0_0000_0000_0000; // +1
            3:  pick = 64'hBFF0_0000_0000_0000; // -1
            4:  pick = 64'h4000_0000_0000_0000; // +2
            5:  pick = 64'hC000_0000_0000_0000; // -2
            6:  pick = 64'h7FF0_0000_0000_0000; // +inf
            7:  pick = 64'hFFF0_0000_0000_0000; // -inf
            8:  pick = 64'h7FEF_FFFF_FFFF_FFFF; // max finite
            9:  pick = 64'h0000_0000_0000_0001; // min subnormal
            10: pick = 64'h8000_0000_0000_0001; // -min subnormal
            11: pick = 64'h7FF8_0000_0000_0000; // quiet NaN
            12: pick = 64'hFFF0_0000_0000_0001; // signaling NaN, negative
            13: pick = 64'h7FF4_0000_0000_0000; // signaling NaN
            default: pick = 64'hFFFC_0000_0000_0005; // quiet NaN with payload
        endcase
    endfunction

    function automatic bit is_nan(input logic [63:0] v);
        return (v[62:52] == 11'h7FF) && (v[51:0] != 52'h0);
    endfunction
    function automatic bit is_snan(input logic [63:0] v);
        return is_nan(v) && !v[51];
    endfunction
    function automatic bit is_qnan(input logic [63:0] v);
        return (v[62:52] == 11'h7FF) && v[51];
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    logic [31:0] model_cr;

    task automatic run_one(input logic [63:0] a, input logic [63:0] b,
                           input logic [2:0] f, input bit ord, input bit summ);
        logic [3:0]  exp_code;
        logic [3:0]  exp_flags;
        logic [31:0] mask;
        real ra, rb;
        bit  nan_any;
        @(negedge clk);
        op_a = a; op_b = b; field_idx = f;
        ordered_mode = ord; exc_summary = summ; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;

        nan_any = is_nan(a) || is_nan(b);
        if (nan_any) begin
            exp_code = 4'b0001;
        end else begin
            ra = $bitstoreal(a);
            rb = $bitstoreal(b);
            if (ra < rb)      exp_code = 4'b1000;
            else if (ra > rb) exp_code = 4'b0100;
            else              exp_code = 4'b0010;
        end
        exp_flags = 4'b0000;
        if (ord) begin
            if (nan_any)
                exp_flags = {2'b11, is_snan(a) || is_snan(b),
                             is_qnan(a) || is_qnan(b) || !summ};
        end else if (is_snan(a) || is_snan(b)) begin
            exp_flags = 4'b1110;
        end
        mask     = 32'hF000_0000 >> (4 * f);
        model_cr = (model_cr & ~mask) | (({exp_code, 28'h0}) >> (4 * f));

        if (nan_any)
            check("R5 unordered code", {28'h0, fp_cc}, {28'h0, exp_code});
        else if ((a[62:0] == 63'h0) && (b[62:0] == 63'h0))
            check("R4 signed zeros equal", {28'h0, fp_cc}, {28'h0, exp_code});
        else
            check("R3 ordering", {28'h0, fp_cc}, {28'h0, exp_code});
        check("R2 one-hot code", $countones(fp_cc), 1);
        check("R6 field merge", cond_reg, model_cr);
        check("R7 cc matches field", {28'h0, fp_cc}, (cond_reg << (4 * f)) >> 28);
        if (ord)
            check("R9 ordered flags", {28'h0, flag_set}, {28'h0, exp_flags});
        else
            check("R8 unordered flags", {28'h0, flag_set}, {28'h0, exp_flags});
        check("R10 out_valid pulse", {31'h0, out_valid}, 32'h1);
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; op_a = '0; op_b = '0;
        field_idx = '0; ordered_mode = 1'b0; exc_summary = 1'b0;
        model_cr = 32'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset cond_reg", cond_reg, 32'h0);
        check("R1 reset fp_cc", {28'h0, fp_cc}, 32'h0);
        check("R1 reset flags", {28'h0, flag_set}, 32'h0);
        check("R1 reset out_valid", {31'h0, out_valid}, 32'h0);

        for (int ord = 0; ord < 2; ord++) begin
            for (int s = 0; s < 2; s++) begin
                for (int i = 0; i < 15; i++) begin
                    for (int j = 0; j < 15; j++) begin
                        run_one(pick(i), pick(j), 3'((i + j + ord + s) % 8), ord[0], s[0]);
                    end
                end
                // idle cycle with changing inputs: nothing may move
                op_a = pick(13); op_b = pick(3); field_idx = 3'd5;
                @(negedge clk);
                @(negedge clk);
                check("R10 idle holds cond_reg", cond_reg, model_cr);
                check("R10 idle flags zero", {28'h0, flag_set}, 32'h0);
                check("R10 idle out_valid low", {31'h0, out_valid}, 32'h0);
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule